// File: doc/BRIEF.md
# FIFO Write-Back Cache Tag Directory

This block keeps the tags and line state for a 128-byte cache. The cache is built from four ways of 32-byte lines. That leaves a single set, so the cache is fully associative and the stored tag is the whole block number, which is the byte address shifted right by the line offset. Line data and the memory bus are handled elsewhere. The directory decides hit or miss, tracks a dirty bit per way, picks the victim on a miss and reports the block that leaves the cache. It also keeps running hit, miss and access-time figures.

Requests arrive on a valid/ready stream carrying a byte address and a write flag. A request is taken on any clock edge where `req_valid` and `req_ready` are both high, and its result appears in a response register on the following cycle. The response stays valid and unchanged until `rsp_ready` is seen high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle, so a consumer that stalls stops the request side on the same cycle. Replacement is first-in first-out: hits never change the eviction order. Lines are write-back with write-allocate.

Top module: `fifo_cache_dir`

## Requirements
- R1: Synchronous active-low reset clears the response register, all three statistics and every valid and dirty bit. The first access to any address after reset is therefore a miss.
- R2: The block number is `req_addr >> 5`. An access hits exactly when a valid way holds that block number, and `rsp_hit` is 1 for a hit.
- R3: On a miss, empty ways are filled before any valid way is replaced, lowest-numbered empty way first.
- R4: Once all ways are valid, a miss replaces the way that was filled earliest. Hits do not change this order.
- R5: A write hit sets the dirty bit of the hit way. A read hit leaves the dirty bit unchanged. The dirty bit is observed later through `rsp_wb` when that way is evicted.
- R6: A miss installs the new block with its dirty bit equal to the request's write flag.
- R7: On a miss that replaces a valid way, `rsp_evict` is 1, `rsp_evict_blk` gives the replaced block number and `rsp_wb` equals that way's dirty bit. In every other response, `rsp_evict` and `rsp_wb` are 0.
- R8: `hit_cnt` and `miss_cnt` are 16-bit counters of accepted hits and misses. Each saturates at 65535.
- R9: `time_acc` grows by 4 for every accepted access and by a further 40 for every miss, saturating at its maximum.
- R10: A request is accepted when `req_valid && req_ready`. Its response is valid on the next cycle. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid && !rsp_ready`, the response fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_addr | input | 16 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response register full |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Access hit |
| rsp_evict | output | 1 | A valid block was replaced |
| rsp_evict_blk | output | 11 | Block number of the replaced block |
| rsp_wb | output | 1 | Replaced block must be written back |
| hit_cnt | output | 16 | Saturating hit count |
| miss_cnt | output | 16 | Saturating miss count |
| time_acc | output | 32 | Accumulated access time in cycles |

## Verification
The bench replays a 19-access sequence of alternating reads and writes that fills the cache, then keeps replacing lines while re-hitting older ones. A design that updated the order on hits, like LRU, would report different victims. A design that forgot dirty state on write hits would miss write-backs. The bench also stalls the consumer to show that a design that overwrote or dropped a held response, or that accepted while full, differs from the model. A long run of 65,540 hits pushes the hit counter past its limit, so a counter that wraps would read a small value instead of 65535.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
  typedef struct packed {
    logic hit;
    logic evict;
    logic wb;
  } cdir_flags_t;
endpackage

// File: rtl/cdir_match.sv
module cdir_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           look_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == look_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_way = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cdir_victim.sv
module cdir_victim #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  vld,
  input  logic             fill,
  output logic [IDX_W-1:0] vic_way
);
  logic [IDX_W-1:0] ptr_q;
  logic             any_free;
  logic [IDX_W-1:0] free_way;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        any_free = 1'b1;
        free_way = IDX_W'(i);
      end
    end
  end

  assign vic_way = any_free ? free_way : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (fill) ptr_q <= ptr_q + 1'b1;
  end

  // R4: the order pointer moves only when a line is filled
  a_r4_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !fill |=> $stable(ptr_q));
endmodule

// File: rtl/cdir_stats.sv
module cdir_stats #(
  parameter int CNT_W    = 16,
  parameter int TIME_W   = 32,
  parameter int HIT_CYC  = 4,
  parameter int MISS_PEN = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              miss,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic [TIME_W-1:0] time_acc
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [TIME_W-1:0] TIME_MAX = '1;

  logic [TIME_W:0] t_sum;
  assign t_sum = {1'b0, time_acc} + (TIME_W+1)'(HIT_CYC)
               + (miss ? (TIME_W+1)'(MISS_PEN) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
      time_acc <= '0;
    end else if (acc) begin
      if (!miss && hit_cnt != CNT_MAX)  hit_cnt  <= hit_cnt + 1'b1;
      if (miss && miss_cnt != CNT_MAX)  miss_cnt <= miss_cnt + 1'b1;
      time_acc <= t_sum[TIME_W] ? TIME_MAX : t_sum[TIME_W-1:0];
    end
  end

  a_r8_hits_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hit_cnt >= $past(hit_cnt));
  a_r8_misses_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> miss_cnt >= $past(miss_cnt));
  a_r9_time_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(time_acc));
endmodule

// File: rtl/fifo_cache_dir.sv
module fifo_cache_dir #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int CNT_W      = 16,
  parameter int TIME_W     = 32,
  parameter int HIT_CYC    = 4,
  parameter int MISS_PEN   = 40,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_evict,
  output logic [TAG_W-1:0]  rsp_evict_blk,
  output logic              rsp_wb,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic [TIME_W-1:0] time_acc
);
  import cdir_pkg::*;

  logic [WAYS-1:0][TAG_W-1:0] tag_q;
  logic [WAYS-1:0]            vld_q;
  logic [WAYS-1:0]            dirty_q;

  logic [TAG_W-1:0] look_tag;
  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [IDX_W-1:0] hit_way;
  logic [IDX_W-1:0] vic_way;
  logic             accept;
  logic             fill;
  cdir_flags_t      flags_d, flags_q;

  assign look_tag  = req_addr[ADDR_W-1:OFF_W];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign fill      = accept && !hit;

  cdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld(vld_q), .tags(tag_q), .look_tag(look_tag),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way)
  );

  cdir_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .fill(fill), .vic_way(vic_way)
  );

  cdir_stats #(.CNT_W(CNT_W), .TIME_W(TIME_W), .HIT_CYC(HIT_CYC),
               .MISS_PEN(MISS_PEN)) u_stats (
    .clk(clk), .rst_n(rst_n), .acc(accept), .miss(!hit),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .time_acc(time_acc)
  );

  always_comb begin
    flags_d.hit   = hit;
    flags_d.evict = !hit && vld_q[vic_way];
    flags_d.wb    = !hit && vld_q[vic_way] && dirty_q[vic_way];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
    end else if (accept) begin
      if (hit) begin
        if (req_write) dirty_q[hit_way] <= 1'b1;
      end else begin
        vld_q[vic_way]   <= 1'b1;
        tag_q[vic_way]   <= look_tag;
        dirty_q[vic_way] <= req_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      flags_q       <= '0;
      rsp_evict_blk <= '0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      flags_q       <= flags_d;
      rsp_evict_blk <= tag_q[vic_way];
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  assign rsp_hit   = flags_q.hit;
  assign rsp_evict = flags_q.evict;
  assign rsp_wb    = flags_q.wb;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) &&
      $stable(rsp_evict) && $stable(rsp_wb) && $stable(rsp_evict_blk));
  a_r7_wb_needs_evict: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wb |-> rsp_evict);
  a_r7_evict_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_evict |-> !rsp_hit);
  a_r2_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r3_valid_grows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(vld_q) >= $past($countones(vld_q)));
endmodule

// File: tb/fifo_cache_dir_tb.sv
module fifo_cache_dir_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_evict, rsp_wb;
  logic [10:0] rsp_evict_blk;
  logic [15:0] hit_cnt, miss_cnt;
  logic [31:0] time_acc;

  always #5 clk = ~clk;

  fifo_cache_dir u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_evict(rsp_evict),
    .rsp_evict_blk(rsp_evict_blk), .rsp_wb(rsp_wb), .hit_cnt(hit_cnt),
    .miss_cnt(miss_cnt), .time_acc(time_acc)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // reference model state
  bit      m_vld[4];
  int      m_tag[4];
  bit      m_dirty[4];
  int      m_order[$];
  bit      e_rv, e_hit, e_ev, e_wb;
  int      e_blk;
  longint  e_hits, e_miss, e_time;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_vld[i] = 0; m_tag[i] = 0; m_dirty[i] = 0;
    end
    m_order.delete();
    e_rv = 0; e_hit = 0; e_ev = 0; e_wb = 0; e_blk = 0;
    e_hits = 0; e_miss = 0; e_time = 0;
  endtask

  task automatic compare();
    chk(rsp_valid == e_rv, "R10 rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin
      chk(rsp_hit == e_hit, "R2 rsp_hit", rsp_hit, e_hit);
      chk(rsp_evict == e_ev, "R3/R4/R7 rsp_evict", rsp_evict, e_ev);
      chk(rsp_wb == e_wb, "R5/R6/R7 rsp_wb", rsp_wb, e_wb);
      if (e_ev) chk(rsp_evict_blk == e_blk, "R4/R7 rsp_evict_blk", rsp_evict_blk, e_blk);
    end
    chk(hit_cnt == e_hits, "R8 hit_cnt", hit_cnt, e_hits);
    chk(miss_cnt == e_miss, "R8 miss_cnt", miss_cnt, e_miss);
    chk(time_acc == e_time, "R9 time_acc", time_acc, e_time);
  endtask

  task automatic model_access(input int a, input bit w);
    int  blk, way;
    bit  h;
    blk = (a & 16'hFFFF) >> 5;
    h = 0; way = -1;
    for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == blk) begin h = 1; way = i; end
    e_rv = 1; e_hit = h; e_ev = 0; e_wb = 0;
    if (h) begin
      if (w) m_dirty[way] = 1;
      if (e_hits < 65535) e_hits++;
      e_time += 4;
    end else begin
      for (int i = 3; i >= 0; i--) if (!m_vld[i]) way = i;
      if (way < 0) begin
        way = m_order.pop_front();
        e_ev = 1; e_blk = m_tag[way]; e_wb = m_dirty[way];
      end
      m_order.push_back(way);
      m_vld[way] = 1; m_tag[way] = blk; m_dirty[way] = w;
      if (e_miss < 65535) e_miss++;
      e_time += 44;
    end
    if (e_time > 64'hFFFF_FFFF) e_time = 64'hFFFF_FFFF;
  endtask

  // one clock: compare, drive, predict
  task automatic step(input bit v, input int a, input bit w, input bit rdy);
    bit acc;
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a[15:0]; req_write = w; rsp_ready = rdy;
    #1;
    chk(req_ready == (!e_rv || rdy), "R10 req_ready", req_ready, (!e_rv || rdy));
    acc = v && (!e_rv || rdy);
    if (acc) model_access(a, w);
    else if (rdy) e_rv = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; rsp_ready = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  int seq[19] = '{99, 104, 140, 118, 112, 197, 178, 112, 250, 176,
                  125, 223, 133, 277, 256, 212, 163, 174, 184};

  initial begin
    model_reset();
    do_reset();
    // R1: reset state
    step(0, 0, 0, 1);
    chk(hit_cnt == 0 && miss_cnt == 0 && time_acc == 0, "R1 stats clear", hit_cnt, 0);
    // R1/R3: first access after reset misses
    step(1, 99, 0, 1);
    step(0, 0, 0, 1);
    chk(rsp_hit == 0 && rsp_valid == 1, "R1 first access misses", rsp_hit, 0);
    do_reset();
    // R2..R7: alternating read/write sequence with FIFO replacement
    for (int i = 0; i < 19; i++) step(1, seq[i], i % 2, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk(hit_cnt == 9, "R8 sequence hits", hit_cnt, 9);
    chk(miss_cnt == 10, "R8 sequence misses", miss_cnt, 10);
    chk(time_acc == 476, "R9 sequence time", time_acc, 476);
    // R10: back-pressure, held response, rejected request
    step(1, 32 * 40, 1, 0);
    step(1, 32 * 41, 0, 0);
    step(1, 32 * 41, 0, 0);
    step(1, 32 * 41, 0, 1);
    step(1, 32 * 40, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    // R5/R7: write hit dirties a clean line, observed at its eviction
    do_reset();
    step(1, 32 * 1, 0, 1);
    step(1, 32 * 2, 0, 1);
    step(1, 32 * 3, 0, 1);
    step(1, 32 * 4, 0, 1);
    step(1, 32 * 1 + 5, 1, 1);
    step(1, 32 * 2 + 7, 0, 1);
    step(1, 32 * 9, 0, 1);
    step(0, 0, 0, 1);
    chk(rsp_wb == 1 && rsp_evict_blk == 1, "R5 write hit dirty seen at evict", rsp_evict_blk, 1);
    step(1, 32 * 10, 0, 1);
    step(0, 0, 0, 1);
    chk(rsp_wb == 0 && rsp_evict_blk == 2, "R5 read hit stays clean", rsp_evict_blk, 2);
    // R8: saturation of the hit counter
    do_reset();
    for (int i = 0; i < 65540; i++) step(1, 64, 0, 1);
    step(0, 0, 0, 1);
    chk(hit_cnt == 16'hFFFF, "R8 hit saturation", hit_cnt, 65535);
    chk(miss_cnt == 1, "R8 single miss", miss_cnt, 1);
    chk(time_acc == 262200, "R9 long run time", time_acc, 262200);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule